// File: doc/BRIEF.md
# UART Interrupt Register Bank

This block holds the interrupt controls of a serial port. Nine event levels come in from the FIFO and receiver logic. A rising edge on any event sets a sticky status bit. Software sees these bits through a small register window and clears them by writing ones. A mask decides which latched bits reach the single interrupt line. Software never writes the mask directly. It sets mask bits through an enable register and clears them through a disable register, so a bit can be changed without a read-modify-write.

A separate read-only channel status word shows four FIFO levels as they are right now, whatever the mask holds. The bus is a plain strobe interface: address, write strobe, write data and a registered read data word that follows the address by one clock.

Event bit layout, shared by the mask, the status and the enable/disable words: 0 receive trigger, 1 receive empty, 2 receive full, 3 transmit empty, 4 transmit full, 5 overrun, 6 framing, 7 parity, 8 receive timeout. The mask is 13 bits wide. Byte offsets: enable 0x08, disable 0x0C, mask 0x10, status 0x14, channel status 0x2C.

Top module: `uart_irq_regbank`

## Requirements
- R1: A write to offset 0x08 sets every mask bit whose write-data bit is 1. Zero bits and write-data bits 13 and above have no effect.
- R2: A write to offset 0x0C clears every mask bit whose write-data bit is 1. Zero bits have no effect.
- R3: Reads of offsets 0x08, 0x0C and of any unmapped offset return 0. Read data is registered and reflects the address one clock earlier.
- R4: Writes to the mask offset 0x10 and to the channel status offset 0x2C change no state.
- R5: A status bit stays set after its event input falls, until software clears it.
- R6: A status bit sets only on a rising edge of its event. An event that stays high does not set the bit again after it is cleared.
- R7: Writing 1 to a bit at offset 0x14 clears that status bit. Zero bits leave their status bits as they are.
- R8: If an event rises in the same cycle as a clear of its bit, the bit ends up set.
- R9: The interrupt output is the OR of (status AND mask), registered one clock later.
- R10: A read of 0x2C returns the live event levels at bits 0 (receive trigger), 1 (receive empty), 3 (transmit empty) and 4 (transmit full). All other bits read 0. The mask does not affect this word.
- R11: Status bits latch whether or not their mask bit is set.
- R12: After synchronous reset the mask, status, interrupt output and read data are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data for the previous cycle's address |
| evt_lvl | input | NUM_EVT (9) | Event levels in the shared bit layout |
| irq | output | 1 | Interrupt request |

## Verification
A write updates the mask or status at the clock edge where the strobe is sampled. An event sets its status bit at the first edge that sees it high. The interrupt output follows one edge after the status or mask changes. Read data appears one edge after the address is presented.

The bench drives every input on the falling edge. A behavioural reference model advances on each rising edge using the inputs held at that edge. The read data and the interrupt line are compared against the model on every falling edge. The directed checks wait the matching number of edges before they sample.

// File: rtl/irq_bank_pkg.sv
`timescale 1ns/1ps
package irq_bank_pkg;
  parameter int OFS_EN   = 'h08;
  parameter int OFS_DIS  = 'h0C;
  parameter int OFS_MASK = 'h10;
  parameter int OFS_STAT = 'h14;
  parameter int OFS_CHAN = 'h2C;

  parameter int BIT_RXTRIG  = 0;
  parameter int BIT_RXEMPTY = 1;
  parameter int BIT_TXEMPTY = 3;
  parameter int BIT_TXFULL  = 4;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_EN, SEL_DIS, SEL_MASK, SEL_STAT, SEL_CHAN
  } reg_sel_e;
endpackage

// File: rtl/irq_addr_decode.sv
`timescale 1ns/1ps
module irq_addr_decode
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if      (addr == ADDR_W'(OFS_EN))   sel = SEL_EN;
    else if (addr == ADDR_W'(OFS_DIS))  sel = SEL_DIS;
    else if (addr == ADDR_W'(OFS_MASK)) sel = SEL_MASK;
    else if (addr == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
    else if (addr == ADDR_W'(OFS_CHAN)) sel = SEL_CHAN;
    else                                sel = SEL_NONE;
  end
endmodule

// File: rtl/irq_mask_reg.sv
`timescale 1ns/1ps
module irq_mask_reg #(
  parameter int NBITS = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] set_bits,
  input  logic [NBITS-1:0] clr_bits,
  output logic [NBITS-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= (mask_q | set_bits) & ~clr_bits;
  end
endmodule

// File: rtl/irq_status_bit.sv
`timescale 1ns/1ps
module irq_status_bit (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic clr,
  output logic stat
);
  logic evt_q;
  logic rise;
  assign rise = evt & ~evt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= 1'b0;
      stat  <= 1'b0;
    end else begin
      evt_q <= evt;
      if (rise)     stat <= 1'b1;
      else if (clr) stat <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_read_mux.sv
`timescale 1ns/1ps
module irq_read_mux
  import irq_bank_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NBITS   = 13,
  parameter int NUM_EVT = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  reg_sel_e           sel,
  input  logic [NBITS-1:0]   mask,
  input  logic [NBITS-1:0]   stat,
  input  logic [NUM_EVT-1:0] evt,
  output logic [DATA_W-1:0]  rdata
);
  logic [DATA_W-1:0] chan_word;
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    chan_word = '0;
    chan_word[BIT_RXTRIG]  = evt[BIT_RXTRIG];
    chan_word[BIT_RXEMPTY] = evt[BIT_RXEMPTY];
    chan_word[BIT_TXEMPTY] = evt[BIT_TXEMPTY];
    chan_word[BIT_TXFULL]  = evt[BIT_TXFULL];
  end

  always_comb begin
    case (sel)
      SEL_MASK: rd_next = DATA_W'(mask);
      SEL_STAT: rd_next = DATA_W'(stat);
      SEL_CHAN: rd_next = chan_word;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/uart_irq_regbank.sv
`timescale 1ns/1ps
module uart_irq_regbank
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NBITS   = 13,
  parameter int NUM_EVT = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_EVT-1:0] evt_lvl,
  output logic               irq
);
  localparam int SPARE_W = DATA_W - NBITS;

  reg_sel_e         sel;
  logic [NBITS-1:0] wbits;
  logic [NBITS-1:0] set_bits, clr_bits, stat_clr;
  logic [NBITS-1:0] mask_q, stat_q;
  logic             unused_wdata;

  assign wbits        = bus_wdata[NBITS-1:0];
  assign unused_wdata = ^bus_wdata[DATA_W-1:DATA_W-SPARE_W];

  irq_addr_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .sel(sel));

  assign set_bits = (bus_wr && sel == SEL_EN)   ? wbits : '0;
  assign clr_bits = (bus_wr && sel == SEL_DIS)  ? wbits : '0;
  assign stat_clr = (bus_wr && sel == SEL_STAT) ? wbits : '0;

  irq_mask_reg #(.NBITS(NBITS)) u_mask (
    .clk(clk), .rst(rst), .set_bits(set_bits), .clr_bits(clr_bits),
    .mask_q(mask_q)
  );

  for (genvar i = 0; i < NBITS; i++) begin : g_stat
    if (i < NUM_EVT) begin : g_live
      irq_status_bit u_bit (
        .clk(clk), .rst(rst), .evt(evt_lvl[i]), .clr(stat_clr[i]),
        .stat(stat_q[i])
      );
    end else begin : g_tie
      assign stat_q[i] = 1'b0;
    end
  end

  irq_read_mux #(.DATA_W(DATA_W), .NBITS(NBITS), .NUM_EVT(NUM_EVT)) u_rd (
    .clk(clk), .rst(rst), .sel(sel), .mask(mask_q), .stat(stat_q),
    .evt(evt_lvl), .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(stat_q & mask_q);
  end
endmodule

// File: rtl/irq_bank_checker.sv
`timescale 1ns/1ps
module irq_bank_checker
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NBITS   = 13,
  parameter int NUM_EVT = 9
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [NUM_EVT-1:0] evt_lvl,
  input logic               irq,
  input logic [NBITS-1:0]   mask_q,
  input logic [NBITS-1:0]   stat_q
);
  logic [NUM_EVT-1:0] prev_evt;
  logic [NUM_EVT-1:0] rise_v;
  logic [NBITS-1:0]   wb, clr_v;
  logic               unused_chk;

  always_ff @(posedge clk) begin
    if (rst) prev_evt <= '0;
    else     prev_evt <= evt_lvl;
  end

  assign rise_v     = evt_lvl & ~prev_evt;
  assign wb         = bus_wdata[NBITS-1:0];
  assign clr_v      = (bus_wr && bus_addr == ADDR_W'(OFS_STAT)) ? wb : '0;
  assign unused_chk = ^bus_wdata;

  assert_enable_sets_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_EN)) |=> ((mask_q & $past(wb)) == $past(wb)));

  assert_disable_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_DIS)) |=> ((mask_q & $past(wb)) == '0));

  assert_setclr_reads_zero_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == ADDR_W'(OFS_EN) || $past(bus_addr) == ADDR_W'(OFS_DIS))
      |-> (bus_rdata == '0));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    ((($past(stat_q) & ~$past(clr_v)) & ~stat_q) == '0));

  assert_event_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (|rise_v) |=> ((stat_q[NUM_EVT-1:0] & $past(rise_v)) == $past(rise_v)));

  assert_irq_high_R9: assert property (@(posedge clk) disable iff (rst)
    (|(stat_q & mask_q)) |=> irq);

  assert_irq_low_R9: assert property (@(posedge clk) disable iff (rst)
    !(|(stat_q & mask_q)) |=> !irq);
endmodule

bind uart_irq_regbank irq_bank_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBITS(NBITS), .NUM_EVT(NUM_EVT)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_lvl(evt_lvl),
  .irq(irq), .mask_q(mask_q), .stat_q(stat_q)
);

// File: tb/sim_uart_irq_regbank.sv
`timescale 1ns/1ps
module sim_uart_irq_regbank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [8:0]  evt_lvl = 9'h0;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // reference model state
  logic [12:0] m_mask, m_stat;
  logic [8:0]  m_prev;
  logic        m_irq;
  logic [31:0] m_rd;

  always #10 clk = ~clk;

  uart_irq_regbank u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_lvl(evt_lvl), .irq(irq)
  );

  always @(posedge clk) begin
    logic [31:0] rd_n;
    if (rst) begin
      m_mask = '0; m_stat = '0; m_prev = '0; m_irq = 1'b0; m_rd = '0;
    end else begin
      case (bus_addr)
        8'h10:   rd_n = {19'h0, m_mask};
        8'h14:   rd_n = {19'h0, m_stat};
        8'h2C:   rd_n = {27'h0, evt_lvl[4], evt_lvl[3], 1'b0, evt_lvl[1], evt_lvl[0]};
        default: rd_n = '0;
      endcase
      m_irq = (m_stat & m_mask) != 0;
      m_rd  = rd_n;
      if (bus_wr && bus_addr == 8'h08) m_mask = m_mask | bus_wdata[12:0];
      if (bus_wr && bus_addr == 8'h0C) m_mask = m_mask & ~bus_wdata[12:0];
      for (int i = 0; i < 9; i++) begin
        if (evt_lvl[i] && !m_prev[i]) m_stat[i] = 1'b1;
        else if (bus_wr && bus_addr == 8'h14 && bus_wdata[i]) m_stat[i] = 1'b0;
      end
      m_prev = evt_lvl;
    end
  end

  // per-cycle comparison against the model (R3 read timing, R9 interrupt)
  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if (bus_rdata !== m_rd) begin
        bad++;
        $display("FAIL R3 model rdata act=%h exp=%h t=%0t", bus_rdata, m_rd, $time);
      end
      total++;
      if (irq !== m_irq) begin
        bad++;
        $display("FAIL R9 model irq act=%0b exp=%0b t=%0t", irq, m_irq, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R12 rdata after reset", bus_rdata, 32'h0);
    chk("R12 irq after reset", {31'h0, irq}, 32'h0);
    rd(8'h10, v); chk("R12 mask after reset", v, 32'h0);
    rd(8'h14, v); chk("R12 status after reset", v, 32'h0);

    wr(8'h08, 32'h0A5); rd(8'h10, v); chk("R1 enable sets", v, 32'h0A5);
    wr(8'h08, 32'h100); rd(8'h10, v); chk("R1 zeros keep", v, 32'h1A5);
    wr(8'h08, 32'hFFFF_E000); rd(8'h10, v); chk("R1 high bits ignored", v, 32'h1A5);
    wr(8'h0C, 32'h005); rd(8'h10, v); chk("R2 disable clears", v, 32'h1A0);

    rd(8'h08, v); chk("R3 enable reads 0", v, 32'h0);
    rd(8'h0C, v); chk("R3 disable reads 0", v, 32'h0);
    rd(8'h3C, v); chk("R3 unmapped reads 0", v, 32'h0);

    wr(8'h10, 32'h1FFF); rd(8'h10, v); chk("R4 mask write ignored", v, 32'h1A0);
    wr(8'h2C, 32'hFF); rd(8'h2C, v); chk("R4 chan write ignored", v, 32'h0);
    rd(8'h14, v); chk("R4 status untouched", v, 32'h0);

    evt_lvl = 9'h01B;
    rd(8'h2C, v); chk("R10 live chan", v, 32'h01B);
    rd(8'h14, v); chk("R11 masked bits latch", v, 32'h01B);
    chk("R9 masked irq low", {31'h0, irq}, 32'h0);

    wr(8'h14, 32'h003); rd(8'h14, v); chk("R7 w1c partial", v, 32'h018);
    @(negedge clk); rd(8'h14, v); chk("R6 held event no reset", v, 32'h018);
    evt_lvl = 9'h0;
    rd(8'h14, v); chk("R5 sticky after drop", v, 32'h018);
    rd(8'h2C, v); chk("R10 chan follows low", v, 32'h0);

    wr(8'h08, 32'h008);
    @(negedge clk); chk("R9 irq rises", {31'h0, irq}, 32'h1);
    wr(8'h14, 32'h018);
    @(negedge clk); chk("R9 irq falls", {31'h0, irq}, 32'h0);

    evt_lvl = 9'h080; @(negedge clk);
    evt_lvl = 9'h000; @(negedge clk);
    evt_lvl = 9'h080; wr(8'h14, 32'h080);
    rd(8'h14, v); chk("R8 event beats clear", v, 32'h080);
    chk("R9 parity irq", {31'h0, irq}, 32'h1);
    wr(8'h14, 32'h080); rd(8'h14, v); chk("R6 clear with level held", v, 32'h0);
    evt_lvl = 9'h0;

    evt_lvl = 9'h020; @(negedge clk); evt_lvl = 9'h0;
    @(negedge clk); chk("R9 overrun irq", {31'h0, irq}, 32'h1);
    rd(8'h14, v); chk("R5 pulse latched", v, 32'h020);

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule